// File: doc/BRIEF.md
# Ethernet destination address filter

This block decides, for each received frame, whether its 48-bit destination address should be kept. The address is compared against sixteen exact-match entries. Each entry has its own valid flag. When the address is a group (multicast) address, it is also looked up in a 4096-bit hash table. A 2-bit filter type chooses which twelve of the upper address bits form the hash index. An optional control bit accepts the all-ones broadcast address outright.

Software programs the entries, the hash table and the control word through a flat word-addressed register port, and can read each of them back. The hash table can therefore be updated one bit at a time by read-modify-write.

The lookup side takes one address per cycle with a single-cycle strobe. Exactly two cycles later it returns accept or reject, together with a code for the source of the match.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, `res_valid`, `res_accept` and `res_reject` are 0. Every table word, entry word and the control word read back as 0.
- R2: A request strobed on `req_valid` at clock edge N produces `res_valid` at edge N+2. Requests on consecutive cycles each yield a result, in the order they were issued.
- R3: When the address equals a valid exact-match entry, the result is accept with `res_src` = 1 (exact). Address byte k sits in `req_addr[8k+7:8k]`.
- R4: Entry i has a low word at register 0x80+2i, holding bytes 0..3 with byte 0 in bits 7:0. Its high word is at 0x81+2i, with bytes 4..5 in bits 15:0 and the valid flag in bit 31. All other high-word bits read as 0.
- R5: Writing zero to an entry's high word clears its valid flag. After that the entry never matches, whatever its low word holds.
- R6: The hash index is `req_addr[47:36]` for filter type 0, `[46:35]` for type 1, `[45:34]` for type 2 and `[43:32]` for type 3. Index bits 11:5 select table word 0x00..0x7F, and bits 4:0 select the bit within that word.
- R7: A group address (`req_addr[0]` = 1) whose hash bit is set is accepted with `res_src` = 2 (hash). A unicast address is never accepted through the hash table.
- R8: The control word is at 0x A0 written as 0xA0: bits 1:0 are the filter type and bit 2 enables broadcast accept. With that bit set, the all-ones address is accepted with `res_src` = 3. With it clear, the all-ones address goes through the exact and hash checks like any other address.
- R9: Table words, entry words and the control word read back on `cfg_rdata` the values written to them. Unmapped addresses read as 0.
- R10: When more than one source matches, exact takes priority over broadcast, and broadcast takes priority over hash.
- R11: An address that matches no source yields `res_reject` = 1, `res_accept` = 0 and `res_src` = 0. Accept and reject are never both high, and both are low when `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle strobe for a lookup request |
| req_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| res_valid | output | 1 | Result valid, two cycles after the request |
| res_accept | output | 1 | Address accepted |
| res_reject | output | 1 | Address rejected |
| res_src | output | 2 | Match source: 0 none, 1 exact, 2 hash, 3 broadcast |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |

## Verification
The assertions assume that `req_addr` is driven to a known value whenever the block is out of reset, because the broadcast and hash-source checks look two cycles back at the address bits. They also assume that configuration does not change while a lookup is in the pipeline, since the exact compare and the table read happen in different cycles. The stimulus holds `req_addr` at zero during reset. Every register write is done only after the pipeline has drained for several idle cycles, so each expected result depends on a single, settled configuration.

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
  parameter int NUM_ENT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [47:0] req_addr,
  output logic        res_valid,
  output logic        res_accept,
  output logic        res_reject,
  output logic [1:0]  res_src,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata
);
  localparam int TBL_WORDS = 128;
  localparam int IW = $clog2(NUM_ENT);
  localparam logic [7:0] ENT_BASE  = 8'(TBL_WORDS);
  localparam logic [7:0] CTRL_ADDR = 8'(TBL_WORDS + 2 * NUM_ENT);

  logic [31:0]        tbl     [TBL_WORDS];
  logic [47:0]        ent     [NUM_ENT];
  logic [NUM_ENT-1:0] ent_vld;
  logic [1:0]         ftype;
  logic               bc_en;

  logic [7:0]    ent_off;
  logic [IW-1:0] ent_idx;
  logic          in_tbl, in_ent, in_ctrl;

  assign ent_off = cfg_addr - ENT_BASE;
  assign ent_idx = ent_off[IW:1];
  assign in_tbl  = cfg_addr < ENT_BASE;
  assign in_ent  = !in_tbl && cfg_addr < CTRL_ADDR;
  assign in_ctrl = cfg_addr == CTRL_ADDR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TBL_WORDS; i++) tbl[i] <= '0;
      for (int i = 0; i < NUM_ENT; i++) ent[i] <= '0;
      ent_vld <= '0;
      ftype   <= '0;
      bc_en   <= 1'b0;
    end else if (cfg_wr) begin
      if (in_tbl) tbl[cfg_addr[6:0]] <= cfg_wdata;
      else if (in_ent) begin
        if (ent_off[0]) begin
          ent[ent_idx][47:32] <= cfg_wdata[15:0];
          ent_vld[ent_idx]    <= cfg_wdata[31];
        end else begin
          ent[ent_idx][31:0]  <= cfg_wdata;
        end
      end else if (in_ctrl) begin
        ftype <= cfg_wdata[1:0];
        bc_en <= cfg_wdata[2];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (in_tbl) cfg_rdata = tbl[cfg_addr[6:0]];
    else if (in_ent)
      cfg_rdata = ent_off[0] ? {ent_vld[ent_idx], 15'b0, ent[ent_idx][47:32]}
                             : ent[ent_idx][31:0];
    else if (in_ctrl) cfg_rdata = {29'b0, bc_en, ftype};
  end

  // stage 1: exact compare and hash index
  logic [NUM_ENT-1:0] hit_vec;
  logic [11:0]        hash;

  always_comb begin
    for (int i = 0; i < NUM_ENT; i++) hit_vec[i] = ent_vld[i] && (ent[i] == req_addr);
    case (ftype)
      2'd0:    hash = req_addr[47:36];
      2'd1:    hash = req_addr[46:35];
      2'd2:    hash = req_addr[45:34];
      default: hash = req_addr[43:32];
    endcase
  end

  logic        s1_v, s1_hit, s1_bc, s1_grp;
  logic [11:0] s1_hash;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_hit <= 1'b0; s1_bc <= 1'b0; s1_grp <= 1'b0; s1_hash <= '0;
    end else begin
      s1_v    <= req_valid;
      s1_hit  <= |hit_vec;
      s1_bc   <= bc_en && (&req_addr);
      s1_grp  <= req_addr[0];
      s1_hash <= hash;
    end
  end

  // stage 2: table bit and source priority
  logic [31:0] tword;
  logic        hash_hit;
  logic [1:0]  nxt_src;

  assign tword    = tbl[s1_hash[11:5]];
  assign hash_hit = s1_grp && tword[s1_hash[4:0]];
  assign nxt_src  = !s1_v  ? 2'd0 :
                    s1_hit ? 2'd1 :
                    s1_bc  ? 2'd3 :
                    hash_hit ? 2'd2 : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0; res_accept <= 1'b0; res_reject <= 1'b0; res_src <= '0;
    end else begin
      res_valid  <= s1_v;
      res_accept <= s1_v && nxt_src != 2'd0;
      res_reject <= s1_v && nxt_src == 2'd0;
      res_src    <= nxt_src;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ##1 res_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ##1 !res_valid);
  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot({res_accept, res_reject}));
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_accept && !res_reject);
  assert_reject_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_reject |-> res_src == 2'd0);
  assert_hash_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_src == 2'd2 |-> $past(req_addr[0], 2));
  assert_bcast_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_src == 2'd3 |-> $past(&req_addr, 2));
  assert_clear_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && in_ent && ent_off[0] && cfg_wdata == 32'd0 |=> !ent_vld[$past(ent_idx)]);
endmodule

// File: tb/test_dest_addr_filter.sv
`timescale 1ns/1ps
module test_dest_addr_filter;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0;
  logic [47:0] req_addr = '0;
  logic        res_valid, res_accept, res_reject;
  logic [1:0]  res_src;
  logic        cfg_wr = 0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;

  dest_addr_filter i_dest_addr_filter (.*);

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  typedef struct { int due; logic acc; logic [1:0] src; string tag; } exp_t;
  exp_t q[$];

  logic [31:0] sh_tbl [128];
  logic [47:0] sh_ent [16];
  bit          sh_v   [16];
  logic [1:0]  sh_ft = 0;
  bit          sh_bc = 0;

  always @(posedge clk) cyc++;

  function automatic logic [11:0] hash_of(logic [47:0] a, logic [1:0] ft);
    case (ft)
      2'd0: return a[47:36];
      2'd1: return a[46:35];
      2'd2: return a[45:34];
      default: return a[43:32];
    endcase
  endfunction

  function automatic logic [1:0] model(logic [47:0] a);
    logic [11:0] h;
    for (int i = 0; i < 16; i++) if (sh_v[i] && sh_ent[i] == a) return 2'd1;
    if (sh_bc && &a) return 2'd3;
    h = hash_of(a, sh_ft);
    if (a[0] && sh_tbl[h[11:5]][h[4:0]]) return 2'd2;
    return 2'd0;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        check(res_valid, e.tag, "res_valid", 48'(res_valid), 48'd1);
        check(res_accept == e.acc && res_reject == !e.acc && res_src == e.src, e.tag,
              "accept/reject/src", {res_accept, res_reject, res_src},
              {e.acc, !e.acc, e.src});
      end else if (res_valid) begin
        check(0, "R2", "unexpected res_valid", 48'd1, 48'd0);
      end
    end
  end

  task automatic send(logic [47:0] a, string tag);
    exp_t e;
    logic [1:0] s;
    @(negedge clk);
    s = model(a);
    req_valid = 1; req_addr = a;
    e.due = cyc + 2; e.src = s; e.acc = (s != 0); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic send_exp(logic [47:0] a, logic [1:0] exp_src, string tag);
    check(model(a) == exp_src, tag, "bench model", 48'(model(a)), 48'(exp_src));
    send(a, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0; req_addr = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    cfg_addr = a;
    #1 check(cfg_rdata == exp, tag, "readback", 48'(cfg_rdata), 48'(exp));
  endtask

  task automatic set_entry(int i, logic [47:0] a, bit v);
    wr(8'(8'h80 + 2 * i), a[31:0]);
    wr(8'(8'h81 + 2 * i), {v, 15'b0, a[47:32]});
    sh_ent[i] = a; sh_v[i] = v;
  endtask

  task automatic set_hash_bit(logic [11:0] h);
    sh_tbl[h[11:5]][h[4:0]] = 1'b1;
    wr({1'b0, h[11:5]}, sh_tbl[h[11:5]]);
  endtask

  task automatic set_ctrl(logic [1:0] ft, bit bc);
    sh_ft = ft; sh_bc = bc;
    wr(8'hA0, {29'b0, bc, ft});
  endtask

  localparam logic [47:0] STATION = 48'h6655_4433_2210;
  localparam logic [47:0] MCAST   = 48'hAABB_CCDD_EE01;
  localparam logic [47:0] HADDR   = 48'h9A5C_3E71_0F03;
  localparam logic [47:0] ONES    = 48'hFFFF_FFFF_FFFF;

  initial begin
    for (int i = 0; i < 128; i++) sh_tbl[i] = '0;
    for (int i = 0; i < 16; i++) begin sh_ent[i] = '0; sh_v[i] = 0; end
    repeat (3) @(negedge clk);
    check(!res_valid && !res_accept && !res_reject, "R1", "outputs in reset",
          {res_valid, res_accept, res_reject}, 48'd0);
    rst_n = 1;
    rd_chk(8'h05, 32'd0, "R1");
    rd_chk(8'h81, 32'd0, "R1");
    rd_chk(8'hA0, 32'd0, "R1");

    set_entry(0, STATION, 1);
    rd_chk(8'h80, 32'h4433_2210, "R4");
    rd_chk(8'h81, 32'h8000_6655, "R4");
    rd_chk(8'hF0, 32'd0, "R9");
    send_exp(STATION, 2'd1, "R3");
    send_exp(48'h6655_4433_2212, 2'd0, "R11");
    idle();

    set_entry(3, MCAST, 1);
    send_exp(MCAST, 2'd1, "R3");
    idle();
    wr(8'h87, 32'd0); sh_v[3] = 0;
    rd_chk(8'h87, 32'd0, "R5");
    rd_chk(8'h86, MCAST[31:0], "R5");
    send_exp(MCAST, 2'd0, "R5");
    idle();

    for (int t = 0; t < 4; t++) begin
      set_ctrl(2'(t), 0);
      send_exp(HADDR, 2'd0, "R6");
      idle();
      set_hash_bit(hash_of(HADDR, 2'(t)));
      send_exp(HADDR, 2'd2, "R6");
      send_exp(HADDR & ~48'd1, 2'd0, "R7");
      idle();
    end
    rd_chk({1'b0, hash_of(HADDR, 2'd0) >> 5}, sh_tbl[hash_of(HADDR, 2'd0) >> 5], "R9");
    rd_chk(8'hA0, 32'd3, "R9");

    set_ctrl(2'd0, 0);
    send_exp(ONES, 2'd0, "R8");
    idle();
    set_ctrl(2'd0, 1);
    rd_chk(8'hA0, 32'd4, "R8");
    send_exp(ONES, 2'd3, "R8");
    idle();
    set_hash_bit(12'hFFF);
    send_exp(ONES, 2'd3, "R10");
    idle();
    set_ctrl(2'd0, 0);
    send_exp(ONES, 2'd2, "R7");
    idle();
    set_ctrl(2'd0, 1);
    set_entry(5, ONES, 1);
    send_exp(ONES, 2'd1, "R10");
    idle();

    send(STATION, "R2");
    send(HADDR, "R2");
    send(48'h0000_0000_0001, "R2");
    send(ONES, "R2");
    send(MCAST, "R2");
    send(HADDR & ~48'd1, "R2");
    idle();
    check(q.size() == 0, "R2", "results outstanding", 48'(q.size()), 48'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule